// File: doc/BRIEF.md
# Two-Operand Four-Function Arithmetic-Logic Unit

This block is a small combinational arithmetic-logic unit. It takes two operand words of equal width and a 2-bit function code. It returns one result word of the same width, together with a carry flag. The function code picks one of four results: the sum of the operands, the inverse of the first operand, their bitwise OR, or their bitwise AND. The unit holds no state. It has no clock and no reset, so the output follows the inputs as soon as the logic settles.

Inside, a control decoder turns the function code into a one-hot set of select strobes. A datapath computes all four candidate results and gates the selected one onto the output. The adder is a ripple chain: bit 0 uses a half adder and every higher bit uses a full adder. The operand width is a parameter with a default of 2 bits.

Top module: `alu2_top`

## Requirements
- R1: With funcSel = 2'b00 the result equals (opA + opB) modulo 2^W, where W is the operand width. Any bit above the top bit of the sum is dropped from result.
- R2: With funcSel = 2'b00, carryOut equals the carry out of the most significant bit of the addition.
- R3: With funcSel = 2'b01 the result equals the bitwise inverse of opA.
- R4: With funcSel = 2'b10 the result equals opA | opB.
- R5: With funcSel = 2'b11 the result equals opA & opB.
- R6: carryOut is 0 whenever funcSel is not 2'b00.
- R7: With funcSel = 2'b01, changing opB leaves result unchanged.
- R8: The unit is purely combinational. The same inputs give the same outputs whatever inputs came before, and the outputs settle with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand word |
| opB | input | W | Second operand word |
| funcSel | input | 2 | Function code: 00 add, 01 invert opA, 10 OR, 11 AND |
| result | output | W | Selected result word |
| carryOut | output | 1 | Adder carry out of the top bit; 0 for the other functions |

## Verification
The bench builds two copies of the unit. The first uses the default width of 2 and the second uses a width of 3, and one sweep drives every combination of operands and function code into both. At width 2 the sweep covers all 64 input combinations. At width 3 the carry must pass through a second full adder, so the generate branch for the middle bits and the carry chain that feeds the top bit are both exercised. Further passes hold opA and vary opB under the invert code, then replay earlier inputs in a different order to show that no history is kept.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_INV = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic addSel;
    logic invSel;
    logic orSel;
    logic andSel;
  } aluStrobe_t;

endpackage

// File: rtl/alu2_ctrl.sv
module alu2_ctrl
  import alu2_pkg::*;
(
  input  logic [1:0] funcSel,
  output aluStrobe_t strobes
);

  aluOp_e opCode;

  always_comb begin
    opCode  = aluOp_e'(funcSel);
    strobes = '0;
    unique case (opCode)
      OP_ADD:  strobes.addSel = 1'b1;
      OP_INV:  strobes.invSel = 1'b1;
      OP_OR:   strobes.orSel  = 1'b1;
      OP_AND:  strobes.andSel = 1'b1;
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu2_fulladd.sv
module alu2_fulladd (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);

  logic halfSum;

  assign halfSum = x ^ y;
  assign sum     = halfSum ^ cin;
  assign cout    = (x & y) | (halfSum & cin);

endmodule

// File: rtl/alu2_datapath.sv
module alu2_datapath
  import alu2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluStrobe_t   strobes,
  output logic [W-1:0] result,
  output logic         carryOut
);

  localparam int TOP = W - 1;

  logic [W-1:0] sumBits;
  logic [W-1:0] carryBits;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_half
        assign sumBits[i]   = opA[i] ^ opB[i];
        assign carryBits[i] = opA[i] & opB[i];
      end else begin : g_full
        alu2_fulladd u_fa (
          .x    (opA[i]),
          .y    (opB[i]),
          .cin  (carryBits[i-1]),
          .sum  (sumBits[i]),
          .cout (carryBits[i])
        );
      end
    end
  endgenerate

  logic [W-1:0] invBits;
  logic [W-1:0] orBits;
  logic [W-1:0] andBits;

  assign invBits = ~opA;
  assign orBits  = opA | opB;
  assign andBits = opA & opB;

  assign result = ({W{strobes.addSel}} & sumBits)
                | ({W{strobes.invSel}} & invBits)
                | ({W{strobes.orSel}}  & orBits)
                | ({W{strobes.andSel}} & andBits);

  assign carryOut = strobes.addSel & carryBits[TOP];

endmodule

// File: rtl/alu2_top.sv
module alu2_top
  import alu2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [1:0]   funcSel,
  output logic [W-1:0] result,
  output logic         carryOut
);

  aluStrobe_t strobes;

  alu2_ctrl u_ctrl (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  alu2_datapath #(.W(W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/alu2_checker.sv
module alu2_checker #(
  parameter int W = 2
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [1:0]   funcSel,
  input logic [W-1:0] result,
  input logic         carryOut
);

  logic [W:0] wideSum;

  always_comb begin
    wideSum = {1'b0, opA} + {1'b0, opB};
    if (funcSel == 2'b00) begin
      a_r1_add_wraps: assert (result == wideSum[W-1:0])
        else $error("R1 add result mismatch");
      a_r2_carry_top: assert (carryOut == wideSum[W])
        else $error("R2 carry mismatch");
    end
    if (funcSel == 2'b01) begin
      a_r3_invert: assert ((result ^ opA) == {W{1'b1}})
        else $error("R3 invert mismatch");
    end
    if (funcSel == 2'b10) begin
      a_r4_or: assert (result == (opA | opB))
        else $error("R4 or mismatch");
    end
    if (funcSel == 2'b11) begin
      a_r5_and: assert (result == (opA & opB))
        else $error("R5 and mismatch");
    end
    if (funcSel != 2'b00) begin
      a_r6_no_carry: assert (carryOut == 1'b0)
        else $error("R6 carry not zero");
    end
  end

endmodule

bind alu2_top alu2_checker #(.W(W)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .funcSel  (funcSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/alu2_top_test.sv
module alu2_top_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] a2, b2, sel;
  logic [2:0] a3, b3;
  logic [1:0] res2;
  logic [2:0] res3;
  logic       co2, co3;

  alu2_top #(.W(2)) uut (
    .opA(a2), .opB(b2), .funcSel(sel), .result(res2), .carryOut(co2)
  );

  alu2_top #(.W(3)) uut3 (
    .opA(a3), .opB(b3), .funcSel(sel), .result(res3), .carryOut(co3)
  );

  typedef struct {
    string tag;
    int    sel;
    int    expC2;
    int    expCo2;
    int    expC3;
    int    expCo3;
  } item_t;

  item_t queueExp[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic int modelC(int w, int s, int a, int b);
    int mask = (1 << w) - 1;
    case (s)
      0:       return (a + b) & mask;
      1:       return (~a) & mask;
      2:       return (a | b) & mask;
      default: return (a & b) & mask;
    endcase
  endfunction

  function automatic int modelCo(int w, int s, int a, int b);
    if (s != 0) return 0;
    return ((a + b) >> w) & 1;
  endfunction

  function automatic string selTag(int s);
    case (s)
      0:       return "R1";
      1:       return "R3";
      2:       return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(string tag, int s, int a, int b);
    item_t it;
    @(posedge clk);
    #2;
    sel = s[1:0];
    a3  = a[2:0];
    b3  = b[2:0];
    a2  = a[1:0];
    b2  = b[1:0];
    it.tag    = tag;
    it.sel    = s;
    it.expC2  = modelC(2, s, a & 3, b & 3);
    it.expCo2 = modelCo(2, s, a & 3, b & 3);
    it.expC3  = modelC(3, s, a & 7, b & 7);
    it.expCo3 = modelCo(3, s, a & 7, b & 7);
    queueExp.push_back(it);
  endtask

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (queueExp.size() > 0) begin
        string coTag;
        it = queueExp.pop_front();
        coTag = (it.sel == 0) ? "R2" : "R6";
        checkVal(it.tag, "w2 result", int'(res2), it.expC2);
        checkVal(it.tag, "w3 result", int'(res3), it.expC3);
        checkVal(coTag,  "w2 carryOut", int'(co2), it.expCo2);
        checkVal(coTag,  "w3 carryOut", int'(co3), it.expCo3);
      end
    end
  end

  initial begin : driver
    sel = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0;
    // R8 idle state: all-zero inputs give zero outputs with no clock dependence
    drive("R8 idle", 0, 0, 0);
    // R1 R2 R3 R4 R5 R6: exhaustive sweep (covers all 64 width-2 cases)
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          drive(selTag(s), s, a, b);
    // R7: invert code, opA held, opB swept; expected result never depends on opB
    for (int a = 0; a < 8; a++)
      for (int b = 7; b >= 0; b--)
        drive("R7", 1, a, b);
    // R8: replay in reverse order and interleaved codes; no history retained
    for (int k = 63; k >= 0; k--)
      drive("R8", k & 3, (k >> 2) & 7, (k * 5) & 7);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule